// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects interrupt events from a small processor core and its peripherals and turns them into one request line towards the CPU. Each of the nine sources owns a sticky flag and a mask bit. Three core sources (external pin edge, timer-0 overflow, port change) keep both bits in a control register. Six peripheral sources (timer-1, timer-2, capture/compare, serial port, converter done, non-volatile write done) keep their flags in one register and their masks in another. Flags latch whether or not anything is enabled. A peripheral-group enable gates all six peripheral sources together. A global enable, above it, gates every source.

When the CPU accepts the request, the global enable drops by itself and the block presents the fixed handler address. A return strobe raises the global enable again, so any flag that software has not cleared fires again at once. While the core sleeps, a wake output reports any enabled, flagged source, whatever the global enable. Core events arrive asynchronously. They pass through a two-stage synchroniser and become flags only at the end of a four-phase instruction cycle, which gives a latency of several clocks that depends on phase.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the three registers read zero (global enable clear), and `irq_o`, `wake_o` and `vector_o` are low.
- R2: A one-clock pulse on `periph_evt_i[k]` sets peripheral flag k at the next clock edge. This happens even when its mask, the group enable and the global enable are all clear.
- R3: A core event pulse on `core_evt_i[k]` sets core flag k no sooner than the 4th and no later than the 7th rising edge after it is first sampled, whatever the masks. Core flags change only on a control-register write or on the last phase of the four-clock phase counter.
- R4: `irq_o` is high exactly when the global enable is set and either some core flag has its mask set, or the group enable is set and some peripheral flag has its mask set.
- R5: A peripheral source raises no request while the group enable is clear. A core source needs only its own mask and the global enable.
- R6: While `irq_o` is high, a high `irq_take_i` clears the global enable at the next edge and drives `vector_o` to 0x0004 in that cycle. At all other times `vector_o` is zero.
- R7: A high `irq_ret_i` sets the global enable at the next edge. A take in the same cycle wins.
- R8: Flags clear only through register writes. A flag left set raises `irq_o` again as soon as the global enable returns.
- R9: If a write that clears a flag meets a new event for that flag in the same cycle, the flag ends up set.
- R10: `wake_o` is high when `sleep_i` is high and some source passes its mask and group gating, regardless of the global enable.
- R11: Register selects are 0 = control, 1 = peripheral flags, 2 = peripheral masks. Control bits are: [7] global enable, [6] group enable, [5:3] core masks, [2:0] core flags (0 pin edge, 1 timer-0, 2 port change). Peripheral bits [5:0] are timer-1, timer-2, capture, serial, converter, write-done. Bits [7:6] of the peripheral registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_evt_i | input | 3 | Asynchronous core event lines |
| periph_evt_i | input | 6 | One-clock peripheral event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 8 | Read data |
| irq_take_i | input | 1 | CPU accepts the interrupt |
| irq_ret_i | input | 1 | Return-from-interrupt strobe |
| sleep_i | input | 1 | Core is in sleep mode |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 13 | Handler address during an accepted take |
| wake_o | output | 1 | Wake-up request |

## Verification
Two situations are hard to reach from the ports. The first is the race between a software write that clears a flag and a fresh event on that same flag. The bench forces it by driving the clearing write and the event pulse on the same falling edge. The second is the phase-dependent latency of core events. The bench pulses a core event once and then samples the control register after the 3rd and after the 7th edge, so that it brackets the permitted window without having to know the internal phase.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned N_CORE      = 3;
    localparam int unsigned N_PERI      = 6;
    localparam int unsigned REG_W       = 8;
    localparam int unsigned SEL_W       = 2;
    localparam int unsigned VEC_W       = 13;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned PHASES      = 4;
    localparam int unsigned PHASE_W     = $clog2(PHASES);
    localparam logic [VEC_W-1:0] HANDLER_ADDR = 13'h0004;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PFLAG = 2'd1,
        SEL_PMASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic              gie;
        logic              grp_en;
        logic [N_CORE-1:0] core_mask;
        logic [N_CORE-1:0] core_flag;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pad_peri(input logic [N_PERI-1:0] v);
        return {{(REG_W-N_PERI){1'b0}}, v};
    endfunction
endpackage

// File: rtl/irq_core_sampler.sv
module irq_core_sampler #(
    parameter int unsigned W      = irq_pkg::N_CORE,
    parameter int unsigned STAGES = irq_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_async_i,
    input  logic         phase_end_i,
    output logic [W-1:0] set_o
);
    logic [W-1:0] pending;

    for (genvar i = 0; i < W; i++) begin : g_src
        logic [STAGES:0] shreg;
        logic            rise;

        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[STAGES-1:0], evt_async_i[i]};
        end

        assign rise = shreg[STAGES-1] & ~shreg[STAGES];

        always_ff @(posedge clk) begin
            if (rst)              pending[i] <= 1'b0;
            else if (phase_end_i) pending[i] <= rise;
            else                  pending[i] <= pending[i] | rise;
        end
    end

    assign set_o = pending & {W{phase_end_i}};
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned W = irq_pkg::N_PERI
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (wr_i ? wr_data_i : q_o) | set_i;
    end
endmodule

// File: rtl/irq_request_gate.sv
module irq_request_gate #(
    parameter int unsigned NC = irq_pkg::N_CORE,
    parameter int unsigned NP = irq_pkg::N_PERI
) (
    input  logic          gie_i,
    input  logic          grp_en_i,
    input  logic          sleep_i,
    input  logic [NC-1:0] core_flag_i,
    input  logic [NC-1:0] core_mask_i,
    input  logic [NP-1:0] peri_flag_i,
    input  logic [NP-1:0] peri_mask_i,
    output logic          irq_o,
    output logic          wake_o
);
    logic core_hit, peri_hit, any_hit;

    assign core_hit = |(core_flag_i & core_mask_i);
    assign peri_hit = grp_en_i & (|(peri_flag_i & peri_mask_i));
    assign any_hit  = core_hit | peri_hit;
    assign irq_o    = gie_i & any_hit;
    assign wake_o   = sleep_i & any_hit;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CORE-1:0]    core_evt_i,
    input  logic [N_PERI-1:0]    periph_evt_i,
    input  logic                 wr_en_i,
    input  logic [SEL_W-1:0]     wr_sel_i,
    input  logic [REG_W-1:0]     wr_data_i,
    input  logic [SEL_W-1:0]     rd_sel_i,
    output logic [REG_W-1:0]     rd_data_o,
    input  logic                 irq_take_i,
    input  logic                 irq_ret_i,
    input  logic                 sleep_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     vector_o,
    output logic                 wake_o
);
    logic [PHASE_W-1:0] phase;
    logic               phase_end;
    logic               gie, grp_en;
    logic [N_CORE-1:0]  core_set, core_flag, core_mask;
    logic [N_PERI-1:0]  peri_flag, peri_mask;
    logic               wr_ctrl, wr_pflag, wr_pmask, take_ok;
    ctrl_t              wr_ctrl_view, rd_ctrl_view;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end
    assign phase_end = (phase == PHASE_W'(PHASES-1));

    assign wr_ctrl      = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);
    assign wr_pflag     = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_PFLAG);
    assign wr_pmask     = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_PMASK);
    assign wr_ctrl_view = ctrl_t'(wr_data_i);
    assign take_ok      = irq_take_i & irq_o;

    irq_core_sampler #(.W(N_CORE), .STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .evt_async_i(core_evt_i),
        .phase_end_i(phase_end), .set_o(core_set)
    );

    irq_flag_bank #(.W(N_CORE)) u_core_flag (
        .clk(clk), .rst(rst), .set_i(core_set), .wr_i(wr_ctrl),
        .wr_data_i(wr_ctrl_view.core_flag), .q_o(core_flag)
    );

    irq_flag_bank #(.W(N_CORE)) u_core_mask (
        .clk(clk), .rst(rst), .set_i('0), .wr_i(wr_ctrl),
        .wr_data_i(wr_ctrl_view.core_mask), .q_o(core_mask)
    );

    irq_flag_bank #(.W(N_PERI)) u_peri_flag (
        .clk(clk), .rst(rst), .set_i(periph_evt_i), .wr_i(wr_pflag),
        .wr_data_i(wr_data_i[N_PERI-1:0]), .q_o(peri_flag)
    );

    irq_flag_bank #(.W(N_PERI)) u_peri_mask (
        .clk(clk), .rst(rst), .set_i('0), .wr_i(wr_pmask),
        .wr_data_i(wr_data_i[N_PERI-1:0]), .q_o(peri_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gie    <= 1'b0;
            grp_en <= 1'b0;
        end else begin
            if (wr_ctrl) grp_en <= wr_ctrl_view.grp_en;
            if (take_ok)        gie <= 1'b0;
            else if (irq_ret_i) gie <= 1'b1;
            else if (wr_ctrl)   gie <= wr_ctrl_view.gie;
        end
    end

    irq_request_gate #(.NC(N_CORE), .NP(N_PERI)) u_gate (
        .gie_i(gie), .grp_en_i(grp_en), .sleep_i(sleep_i),
        .core_flag_i(core_flag), .core_mask_i(core_mask),
        .peri_flag_i(peri_flag), .peri_mask_i(peri_mask),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    assign vector_o = take_ok ? HANDLER_ADDR : '0;

    always_comb begin
        rd_ctrl_view = '{gie: gie, grp_en: grp_en, core_mask: core_mask, core_flag: core_flag};
        case (reg_sel_e'(rd_sel_i))
            SEL_CTRL:  rd_data_o = rd_ctrl_view;
            SEL_PFLAG: rd_data_o = pad_peri(peri_flag);
            SEL_PMASK: rd_data_o = pad_peri(peri_mask);
            default:   rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      gie,
    input logic                      grp_en,
    input logic                      wr_ctrl,
    input logic                      phase_end,
    input logic [N_CORE-1:0]         core_flag,
    input logic [N_CORE-1:0]         core_mask,
    input logic [N_PERI-1:0]         peri_flag,
    input logic [N_PERI-1:0]         periph_evt_i,
    input logic                      irq_take_i,
    input logic                      irq_ret_i,
    input logic                      sleep_i,
    input logic                      irq_o,
    input logic                      wake_o,
    input logic [VEC_W-1:0]          vector_o
);
    p_irq_needs_gie_r4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> gie);

    p_periph_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (|periph_evt_i) |=> ((peri_flag & $past(periph_evt_i)) == $past(periph_evt_i)));

    p_core_flag_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_ctrl && !phase_end) |=> $stable(core_flag));

    p_group_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (!grp_en && !(|(core_flag & core_mask))) |-> !irq_o);

    p_take_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_take_i && irq_o) |=> !gie);

    p_vector_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_take_i && irq_o) |-> (vector_o == HANDLER_ADDR));

    p_ret_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_ret_i && !(irq_take_i && irq_o)) |=> gie);

    p_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (sleep_i && irq_o) |-> wake_o);
endmodule

bind irq_ctrl irq_ctrl_checker u_chk (
    .clk(clk), .rst(rst), .gie(gie), .grp_en(grp_en), .wr_ctrl(wr_ctrl),
    .phase_end(phase_end), .core_flag(core_flag), .core_mask(core_mask),
    .peri_flag(peri_flag), .periph_evt_i(periph_evt_i),
    .irq_take_i(irq_take_i), .irq_ret_i(irq_ret_i), .sleep_i(sleep_i),
    .irq_o(irq_o), .wake_o(wake_o), .vector_o(vector_o)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  core_evt = '0;
    logic [5:0]  periph_evt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        take = 1'b0, ret = 1'b0, sleep = 1'b0;
    logic        irq, wake;
    logic [12:0] vector;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl uut (
        .clk(clk), .rst(rst), .core_evt_i(core_evt), .periph_evt_i(periph_evt),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_take_i(take),
        .irq_ret_i(ret), .sleep_i(sleep), .irq_o(irq), .vector_o(vector),
        .wake_o(wake)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] rd(input logic [1:0] sel);
        rd_sel = sel;
        return rd_data;
    endfunction

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel = sel;
        #0.5;
        chk(req, {8'h00, rd_data}, {8'h00, exp});
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 2'd0, 8'h00);
        rd_chk("R1 pflag", 2'd1, 8'h00);
        rd_chk("R1 pmask", 2'd2, 8'h00);
        chk("R1 irq/wake/vector", {irq, wake, 1'b0, vector}, 16'h0000);
    endtask

    task automatic t_regmap;
        wr(2'd0, 8'h5A);
        rd_chk("R11 ctrl readback", 2'd0, 8'h5A);
        wr(2'd1, 8'hFF);
        rd_chk("R11 pflag upper bits zero", 2'd1, 8'h3F);
        wr(2'd2, 8'h15);
        rd_chk("R11 pmask readback", 2'd2, 8'h15);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        rd_chk("R8 write clears flags", 2'd1, 8'h00);
    endtask

    task automatic t_periph_latch;
        @(negedge clk); periph_evt = 6'b000100;
        @(negedge clk); periph_evt = '0;
        rd_chk("R2 masked flag latches", 2'd1, 8'h04);
        chk("R2 no irq when masked", {15'd0, irq}, 16'd0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_core_latency;
        @(negedge clk); core_evt = 3'b010;
        @(negedge clk); core_evt = '0;
        repeat (2) @(negedge clk);
        rd_chk("R3 flag not before 4th edge", 2'd0, 8'h00);
        repeat (4) @(negedge clk);
        rd_chk("R3 flag by 7th edge", 2'd0, 8'h02);
        repeat (8) @(negedge clk);
        rd_chk("R8 core flag stays set", 2'd0, 8'h02);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_gating;
        wr(2'd2, 8'h01);
        @(negedge clk); periph_evt = 6'b000001;
        @(negedge clk); periph_evt = '0;
        wr(2'd0, 8'h80); #0.5;
        chk("R5 peripheral blocked without group enable", {15'd0, irq}, 16'd0);
        wr(2'd0, 8'hC0); #0.5;
        chk("R4 peripheral request", {15'd0, irq}, 16'd1);
        wr(2'd0, 8'h40); #0.5;
        chk("R4 no request without global enable", {15'd0, irq}, 16'd0);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h89); #0.5;
        chk("R5 core needs no group enable", {15'd0, irq}, 16'd1);
        wr(2'd0, 8'h81); #0.5;
        chk("R4 core masked", {15'd0, irq}, 16'd0);
        wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_take_ret;
        wr(2'd0, 8'h89);
        @(negedge clk); take = 1'b1; #0.5;
        chk("R6 vector during take", {3'd0, vector}, 16'h0004);
        @(negedge clk); take = 1'b0; #0.5;
        chk("R6 vector idle", {3'd0, vector}, 16'h0000);
        rd_chk("R6 global enable cleared, R8 flag kept", 2'd0, 8'h09);
        chk("R6 irq dropped", {15'd0, irq}, 16'd0);
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0; #0.5;
        rd_chk("R7 global enable restored", 2'd0, 8'h89);
        chk("R8 pending flag re-raises irq", {15'd0, irq}, 16'd1);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_set_wins;
        wr(2'd1, 8'h21);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h00; periph_evt = 6'b100000;
        @(negedge clk);
        wr_en = 1'b0; periph_evt = '0;
        rd_chk("R9 set beats clear", 2'd1, 8'h20);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_wake;
        wr(2'd2, 8'h10);
        @(negedge clk); periph_evt = 6'b010000;
        @(negedge clk); periph_evt = '0;
        wr(2'd0, 8'h40); #0.5;
        chk("R10 no wake while awake", {15'd0, wake}, 16'd0);
        sleep = 1'b1; #0.5;
        chk("R10 wake without global enable", {14'd0, wake, irq}, 16'b10);
        wr(2'd2, 8'h00); #0.5;
        chk("R10 masked source no wake", {15'd0, wake}, 16'd0);
        sleep = 1'b0;
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        t_reset();
        t_regmap();
        t_periph_latch();
        t_core_latency();
        t_gating();
        t_take_ret();
        t_set_wins();
        t_wake();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule